// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the device end of a three-wire serial EEPROM link. A host selects it with a chip-select line, toggles a serial clock, and feeds instruction, address and data bits on a single data-in line. The block answers on a data-out pin that has a separate output enable. The pin is driven only while a read is returning data or while the host is polling ready/busy status after a program operation.

Storage is a register file of 64 sixteen-bit words. An organisation input lets the same storage be seen as 128 bytes. The block decodes seven instructions: read, write, erase, erase-all, write-all, program-enable and program-disable. Any operation that changes memory needs a prior enable. Each accepted program operation starts a busy period whose length is a clock-cycle parameter. All serial pins are sampled on the block's system clock, and the serial clock edges are detected from its sampled value.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low, programming is disabled, and every memory word reads 0xFFFF.
- R2: The output enable is low whenever chip select is low. While chip select is high, the output is driven only during read data or status polling.
- R3: Bits are sampled from data-in on rising serial-clock edges while chip select is high. Zeros before the start bit (a 1) are ignored. After the start bit come a 2-bit opcode and then the address, MSB first: 6 bits with organisation=1 (x16) and 7 bits with organisation=0 (x8).
- R4: Read uses opcode 10. After the last address bit the output drives a 0. Each following rising edge presents the next data bit, MSB first. The rising edge after the LSB releases the output.
- R5: Write uses opcode 01 and is followed by one data word, MSB first (16 bits in x16, 8 in x8). When programming is enabled, the word is stored at the address.
- R6: Erase uses opcode 11 and sets the addressed word or byte to all ones when programming is enabled.
- R7: Opcode 00 with the top two address bits 11 enables programming. Opcode 00 with 00 disables it. While disabled, write, erase, erase-all and write-all change nothing and start no busy period.
- R8: Opcode 00 with top address bits 10 sets every word to all ones. Opcode 00 with 01, followed by a data word, fills every word with that data (in x8, both bytes of each word).
- R9: An accepted program operation makes the output drive status while chip select is high: 0 for BUSY_CYCLES clocks, then 1. No instruction is accepted while busy.
- R10: While status is shown, a 1 shifted in is not a start bit. The output stays driven until the next falling serial-clock edge and is then released. Until that happens, no instruction is accepted.
- R11: Dropping chip select abandons a partly shifted instruction, so a write cut short changes nothing.
- R12: In x8, byte address bit 0 selects the high byte (1) or the low byte (0) of word address[6:1]. Read returns 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled on clk |
| di | input | 1 | Serial data in |
| org | input | 1 | Organisation: 1 = x16 words, 0 = x8 bytes |
| dataOut | output | 1 | Serial data out (valid while dataOutEn is high) |
| dataOutEn | output | 1 | Output enable for dataOut |

## Verification
Reads of fresh, written, erased and bulk-filled locations tell a correct address and bit order apart from shifted or reversed ones. Program operations are tried in three conditions: enabled, disabled, and cut short by chip select. This separates memory that changes when it should from memory that changes when it should not. Polling is tried by waiting out the busy period, by dismissing status early, and by sending a read while busy. These cases distinguish the busy length, the release on the falling edge, and the lockout of new instructions. The x8 byte accesses are cross-checked with x16 reads of the same word to confirm which byte lane is used.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  typedef struct packed {
    logic shiftIn;
    logic latchAddr;
    logic loadRead;
    logic shiftRead;
    logic wrWord;
    logic wrAll;
    logic eraseWord;
    logic eraseAll;
  } mwStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_RDATA, S_WDATA, S_DONE
  } mwState_t;
endpackage

// File: rtl/mw_eeprom_dp.sv
module mw_eeprom_dp
  import mw_eeprom_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       org,
  input  logic       di,
  input  mwStrobe_t  strb,
  output logic [1:0] opNow,
  output logic [1:0] subNow,
  output logic       readBit
);
  localparam int AW16   = $clog2(WORDS);
  localparam int AW8    = AW16 + 1;
  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] shiftReg, shiftNext;
  logic [DATA_W:0]   readShift;
  logic [AW8-1:0]    addrReg, addrNow, addrSel;
  logic [AW16-1:0]   wIdx;
  logic              hiSel;
  logic [BYTE_W-1:0] byteData;
  logic [DATA_W-1:0] allData;

  assign shiftNext = {shiftReg[DATA_W-2:0], di};
  assign opNow   = org ? shiftNext[AW16+1:AW16] : shiftNext[AW8+1:AW8];
  assign subNow  = org ? shiftNext[AW16-1:AW16-2] : shiftNext[AW8-1:AW8-2];
  assign addrNow = org ? {1'b0, shiftNext[AW16-1:0]} : shiftNext[AW8-1:0];
  assign addrSel = strb.latchAddr ? addrNow : addrReg;
  assign wIdx    = org ? addrSel[AW16-1:0] : addrSel[AW8-1:1];
  assign hiSel   = addrSel[0];
  assign byteData = shiftNext[BYTE_W-1:0];
  assign allData  = org ? shiftNext : {byteData, byteData};
  assign readBit  = readShift[DATA_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      addrReg   <= '0;
      readShift <= '0;
      for (int w = 0; w < WORDS; w++) mem[w] <= '1;
    end else begin
      if (strb.shiftIn)   shiftReg <= shiftNext;
      if (strb.latchAddr) addrReg  <= addrNow;
      if (strb.loadRead) begin
        if (org) readShift <= {1'b0, mem[wIdx]};
        else     readShift <= {1'b0, hiSel ? mem[wIdx][DATA_W-1:BYTE_W]
                                           : mem[wIdx][BYTE_W-1:0], {BYTE_W{1'b0}}};
      end else if (strb.shiftRead) begin
        readShift <= {readShift[DATA_W-1:0], 1'b0};
      end
      if (strb.wrAll || strb.eraseAll) begin
        for (int w = 0; w < WORDS; w++) mem[w] <= strb.eraseAll ? '1 : allData;
      end else if (strb.wrWord || strb.eraseWord) begin
        if (org)        mem[wIdx] <= strb.eraseWord ? '1 : shiftNext;
        else if (hiSel) mem[wIdx][DATA_W-1:BYTE_W] <= strb.eraseWord ? '1 : byteData;
        else            mem[wIdx][BYTE_W-1:0]      <= strb.eraseWord ? '1 : byteData;
      end
    end
  end

  logic anyWr;
  assign anyWr = strb.wrWord | strb.wrAll | strb.eraseWord | strb.eraseAll;

  // R7: memory only moves on a program strobe from the control
  a_r7_word0_guarded: assert property (@(posedge clk) disable iff (!rstN)
    !anyWr |=> $stable(mem[0]));
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int WORDS       = 64,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cs,
  input  logic       sk,
  input  logic       di,
  input  logic       org,
  input  logic [1:0] opNow,
  input  logic [1:0] subNow,
  output mwStrobe_t  strb,
  output logic       readActive,
  output logic       busy,
  output logic       pollOn
);
  localparam int AW16   = $clog2(WORDS);
  localparam int AW8    = AW16 + 1;
  localparam int BYTE_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 2);
  localparam int BCW    = $clog2(BUSY_CYCLES + 1);

  mwState_t       state;
  logic [CNT_W-1:0] bitCnt, lastCmd, dataLast, readLast;
  logic [BCW-1:0]   busyCnt;
  logic skPrev, skRise, skFall, ewen, allMode, pollFlag, dismissPend, commit;

  assign skRise   = cs & sk & ~skPrev;
  assign skFall   = ~sk & skPrev;
  assign lastCmd  = org ? CNT_W'(AW16 + 1) : CNT_W'(AW8 + 1);
  assign dataLast = org ? CNT_W'(DATA_W - 1) : CNT_W'(BYTE_W - 1);
  assign readLast = org ? CNT_W'(DATA_W) : CNT_W'(BYTE_W);
  assign busy       = busyCnt != '0;
  assign readActive = state == S_RDATA;
  assign pollOn     = pollFlag;

  always_comb begin
    strb = '0;
    if (cs && skRise) begin
      unique case (state)
        S_CMD: begin
          strb.shiftIn = 1'b1;
          if (bitCnt == lastCmd) begin
            strb.latchAddr = 1'b1;
            strb.loadRead  = opNow == 2'b10;
            strb.eraseWord = ewen && opNow == 2'b11;
            strb.eraseAll  = ewen && opNow == 2'b00 && subNow == 2'b10;
          end
        end
        S_RDATA: strb.shiftRead = bitCnt != readLast;
        S_WDATA: begin
          strb.shiftIn = 1'b1;
          if (bitCnt == dataLast) begin
            strb.wrWord = ewen && !allMode;
            strb.wrAll  = ewen && allMode;
          end
        end
        default: ;
      endcase
    end
  end

  assign commit = strb.wrWord | strb.wrAll | strb.eraseWord | strb.eraseAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; bitCnt <= '0; skPrev <= 1'b0; ewen <= 1'b0;
      allMode <= 1'b0; busyCnt <= '0; pollFlag <= 1'b0; dismissPend <= 1'b0;
    end else begin
      skPrev <= sk;
      if (commit) busyCnt <= BCW'(BUSY_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;

      if (commit) begin
        pollFlag <= 1'b1; dismissPend <= 1'b0;
      end else if (dismissPend && skFall) begin
        pollFlag <= 1'b0; dismissPend <= 1'b0;
      end else if (pollFlag && skRise && di) begin
        dismissPend <= 1'b1;
      end

      if (!cs) begin
        state <= S_IDLE; bitCnt <= '0;
      end else if (skRise) begin
        unique case (state)
          S_IDLE: if (di && !busy && !pollFlag) begin
            state <= S_CMD; bitCnt <= '0;
          end
          S_CMD: begin
            if (bitCnt != lastCmd) bitCnt <= bitCnt + 1'b1;
            else begin
              bitCnt <= '0;
              unique case (opNow)
                2'b10: state <= S_RDATA;
                2'b01: begin state <= S_WDATA; allMode <= 1'b0; end
                2'b11: state <= S_DONE;
                default: begin
                  state <= S_DONE;
                  if (subNow == 2'b11) ewen <= 1'b1;
                  if (subNow == 2'b00) ewen <= 1'b0;
                  if (subNow == 2'b01) begin state <= S_WDATA; allMode <= 1'b1; end
                end
              endcase
            end
          end
          S_RDATA: if (bitCnt == readLast) state <= S_DONE;
                   else bitCnt <= bitCnt + 1'b1;
          S_WDATA: if (bitCnt == dataLast) state <= S_DONE;
                   else bitCnt <= bitCnt + 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R9: an instruction starts only when neither busy nor polling
  a_r9_start_when_free: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CMD && $past(state) == S_IDLE) |-> (!$past(busy) && !$past(pollFlag)));
  // R10: status release happens on a falling serial-clock edge after a dismiss bit
  a_r10_release_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pollFlag) |-> ($past(skFall) && $past(dismissPend)));
  // R7: a busy period begins only with programming enabled
  a_r7_busy_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ewen));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_eeprom_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int WORDS       = 64,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic dataOut,
  output logic dataOutEn
);
  mwStrobe_t  strb;
  logic [1:0] opNow, subNow;
  logic       readBit, readActive, busy, pollOn;

  mw_eeprom_ctrl #(.DATA_W(DATA_W), .WORDS(WORDS), .BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cs(cs), .sk(sk), .di(di), .org(org),
    .opNow(opNow), .subNow(subNow), .strb(strb),
    .readActive(readActive), .busy(busy), .pollOn(pollOn));

  mw_eeprom_dp #(.DATA_W(DATA_W), .WORDS(WORDS)) dp_i (
    .clk(clk), .rstN(rstN), .org(org), .di(di), .strb(strb),
    .opNow(opNow), .subNow(subNow), .readBit(readBit));

  assign dataOutEn = cs & (readActive | pollOn);
  assign dataOut   = readActive ? readBit : ~busy;

  // R2: output released as soon as chip select is low
  a_r2_cs_low_release: assert property (@(posedge clk) disable iff (!rstN)
    !cs |-> !dataOutEn);
endmodule

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 200;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic dataOut, dataOutEn;
  int checks = 0, failures = 0;
  logic [15:0] refMem [64];
  bit refEwen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom #(.DATA_W(16), .WORDS(64), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .cs(cs), .sk(sk), .di(di), .org(org),
    .dataOut(dataOut), .dataOutEn(dataOutEn));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2: every clock with chip select low must see the output released
  always @(negedge clk) if (rstN && !cs) chk(!dataOutEn, "R2 cs low release", dataOutEn, 0);

  task automatic pulse(input logic b);
    @(negedge clk) di = b; sk = 1'b1;
    repeat (2) @(negedge clk);
    sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic csHigh(); @(negedge clk) cs = 1'b1; repeat (2) @(negedge clk); endtask
  task automatic csLow();  @(negedge clk) cs = 1'b0; di = 1'b0; repeat (2) @(negedge clk); endtask

  task automatic sendCmd(input logic [1:0] op, input logic [6:0] addr, input int aw);
    pulse(1'b1); pulse(op[1]); pulse(op[0]);
    for (int i = aw - 1; i >= 0; i--) pulse(addr[i]);
  endtask

  task automatic sendData(input logic [15:0] d, input int dw);
    for (int i = dw - 1; i >= 0; i--) pulse(d[i]);
  endtask

  task automatic readCheck(input logic [6:0] addr, input logic [15:0] exp, input string tag);
    int aw = org ? 6 : 7;
    int dw = org ? 16 : 8;
    logic [15:0] got = '0;
    csHigh();
    sendCmd(2'b10, addr, aw);
    chk(dataOutEn && !dataOut, {tag, " R4 dummy zero"}, {dataOutEn, dataOut}, 2'b10);
    for (int i = dw - 1; i >= 0; i--) begin
      pulse(1'b0);
      got[i] = dataOut;
    end
    chk(got == exp, tag, got, exp);
    pulse(1'b0);
    chk(!dataOutEn, {tag, " R4 release after lsb"}, dataOutEn, 0);
    csLow();
  endtask

  // Dismiss status: driven until falling edge, then released (R10)
  task automatic dismiss();
    @(negedge clk) di = 1'b1; sk = 1'b1;
    repeat (2) @(negedge clk);
    chk(dataOutEn, "R10 still driven before fall", dataOutEn, 1);
    sk = 1'b0;
    repeat (2) @(negedge clk);
    chk(!dataOutEn, "R10 released after fall", dataOutEn, 0);
  endtask

  task automatic afterProgram(input string tag);
    if (refEwen) begin
      chk(dataOutEn && !dataOut, {tag, " R9 busy shown"}, {dataOutEn, dataOut}, 2'b10);
      repeat (BUSY + 10) @(negedge clk);
      chk(dataOutEn && dataOut, {tag, " R9 ready shown"}, {dataOutEn, dataOut}, 2'b11);
      dismiss();
    end else begin
      chk(!dataOutEn, {tag, " R7 no status when disabled"}, dataOutEn, 0);
    end
    csLow();
  endtask

  task automatic subOp(input logic [1:0] sub);
    csHigh();
    sendCmd(2'b00, {1'b0, sub, 4'b0}, 6);
    if (sub == 2'b11) refEwen = 1;
    if (sub == 2'b00) refEwen = 0;
  endtask

  task automatic write16(input logic [5:0] a, input logic [15:0] d);
    csHigh(); sendCmd(2'b01, {1'b0, a}, 6); sendData(d, 16);
    if (refEwen) refMem[a] = d;
    afterProgram("R5 write");
  endtask

  task automatic erase16(input logic [5:0] a);
    csHigh(); sendCmd(2'b11, {1'b0, a}, 6);
    if (refEwen) refMem[a] = 16'hFFFF;
    afterProgram("R6 erase");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++) refMem[w] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!dataOutEn, "R1 reset release", dataOutEn, 0);
    readCheck(7'd5, refMem[5], "R1 erased after reset");

    // R7: disabled write does nothing
    write16(6'd3, 16'h1234);
    readCheck(7'd3, refMem[3], "R7 disabled write ignored");

    subOp(2'b11); csLow();
    write16(6'd3, 16'hA5C3);
    readCheck(7'd3, refMem[3], "R5 write readback");

    // R3: leading zeros before start bit
    csHigh(); pulse(1'b0); pulse(1'b0); pulse(1'b0);
    sendCmd(2'b10, 7'd3, 6);
    chk(dataOutEn && !dataOut, "R3 leading zeros dummy", {dataOutEn, dataOut}, 2'b10);
    csLow();
    readCheck(7'd3, 16'hA5C3, "R3 read after zeros");

    // R9: no instruction while busy (status dismissed early)
    csHigh(); sendCmd(2'b01, 7'd4, 6); sendData(16'h0F0F, 16);
    refMem[4] = 16'h0F0F;
    chk(dataOutEn && !dataOut, "R9 busy after write", {dataOutEn, dataOut}, 2'b10);
    dismiss(); csLow();
    csHigh(); sendCmd(2'b10, 7'd4, 6); pulse(1'b0);
    chk(!dataOutEn, "R9 read ignored while busy", dataOutEn, 0);
    csLow();
    repeat (BUSY + 10) @(negedge clk);
    readCheck(7'd4, refMem[4], "R9 write landed");

    erase16(6'd3);
    readCheck(7'd3, refMem[3], "R6 erase readback");

    // R11: aborted instructions
    csHigh(); pulse(1'b1); pulse(1'b1); pulse(1'b0); csLow();
    readCheck(7'd4, refMem[4], "R11 after aborted read");
    csHigh(); sendCmd(2'b01, 7'd4, 6); sendData(16'h0000, 10); csLow();
    csHigh();
    chk(!dataOutEn, "R11 aborted write no status", dataOutEn, 0);
    csLow();
    readCheck(7'd4, refMem[4], "R11 aborted write unchanged");

    // R7: disable then erase ignored
    subOp(2'b00); csLow();
    erase16(6'd4);
    readCheck(7'd4, refMem[4], "R7 erase ignored when disabled");
    subOp(2'b11); csLow();

    // R8: write all and erase all
    csHigh(); sendCmd(2'b00, 7'b0010000, 6); sendData(16'h5A5A, 16);
    for (int w = 0; w < 64; w++) refMem[w] = 16'h5A5A;
    afterProgram("R8 write all");
    readCheck(7'd0, refMem[0], "R8 write all word 0");
    readCheck(7'd63, refMem[63], "R8 write all word 63");
    csHigh(); sendCmd(2'b00, 7'b0100000, 6);
    for (int w = 0; w < 64; w++) refMem[w] = 16'hFFFF;
    afterProgram("R8 erase all");
    readCheck(7'd10, refMem[10], "R8 erase all word 10");

    // R12: byte organisation
    org = 1'b0;
    csHigh(); sendCmd(2'b01, 7'd7, 7); sendData(16'h003C, 8);
    refMem[3][15:8] = 8'h3C;
    afterProgram("R12 byte write");
    readCheck(7'd7, {8'h00, refMem[3][15:8]}, "R12 high byte read");
    readCheck(7'd6, {8'h00, refMem[3][7:0]}, "R12 low byte read");
    org = 1'b1;
    readCheck(7'd3, refMem[3], "R12 word view of byte write");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule